// File: doc/BRIEF.md
# Card-Detect and Sideband Input Conditioner

This block sits between the slow sideband pins of a memory-card slot and the rest of a card host controller. It brings the card-detect, write-protect and out-of-band interrupt pins into the clock domain through two-flop synchronizers. It converts each pin to an active-high level through its own polarity select. The card-detect level is also debounced over one of four periods that are chosen at run time. The out-of-band interrupt is passed on only while its enable is set.

The debounced card-detect level is held in a register. Every change of that level also raises a one-cycle insert or remove pulse. The periods are counted in ticks of a reference strobe `tickEn`, and each debounce code has its own tick-count parameter. The block also drives the enables of the card data-line input buffers. All of them are on during a transaction. Between transactions they are off, except that data line 1 may be kept on so that an asynchronous card interrupt can still be seen.

Top module: `card_sideband_cond`

## Requirements
- R1: The card-detect, write-protect and out-of-band raw pins each pass through two synchronizing flops. A change on `rawWrProt` shows on `writeProtected` two clock edges later and not earlier.
- R2: `detectPolarity` = 0 treats a high `rawDetect` as card present, and 1 treats a low one as present. Flipping the bit counts as a change of the input level and is debounced like one.
- R3: `writeProtected` equals the synchronized `rawWrProt` when `wpPolarity` = 0, and its inverse when `wpPolarity` = 1.
- R4: With `oobEnable` = 0, `oobIrq` stays 0 whatever the out-of-band pin does. With `oobEnable` = 1, `oobIrq` is the synchronized `rawOob` when `oobPolarity` = 0, and its inverse when `oobPolarity` = 1.
- R5: `debounceSel` codes 0, 1, 2 and 3 select `CNT_CODE0` to `CNT_CODE3` ticks, ordered from the shortest period (about 33 us) to the longest (about 8.4 ms). `cardPresent` takes the new normalized level on the edge that ends the selected number of consecutive ticks during which the level differed from `cardPresent`.
- R6: Any return of the normalized card-detect level to the current `cardPresent` value clears the count. A glitch shorter than the period therefore causes no change, and a later change needs a full period.
- R7: A change of `debounceSel` while a count is running clears the count on the next edge. Counting then restarts under the new period.
- R8: The count advances only on edges where `tickEn` is 1. While `tickEn` is 0, `cardPresent` does not change.
- R9: Each rise of `cardPresent` comes with a one-cycle `insertPulse`, and each fall comes with a one-cycle `removePulse`, in the same cycle. The two pulses are never high together.
- R10: `datBufEn` is all ones while `xferActive` = 1. When `xferActive` = 0 it is all zeros if `keepIntLine` = 0. If `keepIntLine` = 1, only bit 1 (data line 1) is set.
- R11: After reset, `cardPresent`, `insertPulse` and `removePulse` are 0, the count is cleared, and the internal code register holds 3, the longest period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Reference tick strobe for debounce counting |
| rawDetect | input | 1 | Card-detect pin, asynchronous |
| rawWrProt | input | 1 | Write-protect pin, asynchronous |
| rawOob | input | 1 | Out-of-band interrupt pin, asynchronous |
| detectPolarity | input | 1 | 0: detect pin active high, 1: active low |
| wpPolarity | input | 1 | 0: write-protect pin active high, 1: active low |
| oobPolarity | input | 1 | 0: out-of-band pin active high, 1: active low |
| oobEnable | input | 1 | Enables out-of-band interrupt detection |
| keepIntLine | input | 1 | Keeps the data line 1 buffer on between transactions |
| debounceSel | input | 2 | Debounce period code |
| xferActive | input | 1 | A transaction is in progress |
| cardPresent | output | 1 | Debounced, active-high card presence |
| insertPulse | output | 1 | One-cycle pulse on card insertion |
| removePulse | output | 1 | One-cycle pulse on card removal |
| writeProtected | output | 1 | Active-high write-protect level |
| oobIrq | output | 1 | Gated, active-high out-of-band interrupt level |
| datBufEn | output | DATA_LINES | Data-line input buffer enables |

## Verification
When `tickEn` is high every cycle, a pin change applied after edge c gives its debounced result and pulse at edge c+2+N, where N is the tick count of the selected code. A polarity flip skips the synchronizer and is due at edge c+N. A code change made after edge c restarts the count and is due at edge c+1+N. When ticks resume after being held off, the result is due N edges after they resume. `writeProtected` and the ungated `oobIrq` follow their pins after two edges. The buffer enables, the out-of-band gating and the polarity of the sideband levels act within the same cycle. The driver stamps each expected pulse with its due cycle, computed from the cycle counter at the moment it drives. The monitor samples on the falling edge and requires every pulse to match the oldest stamp exactly. Any pulse with no stamp is a failure, so early, late, extra or double-width pulses are all caught.

// File: rtl/card_sideband_pkg.sv
package card_sideband_pkg;

  // Strobes from the control FSM to the debounce datapath
  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } dbStrobe_t;

  // Debounce code held after reset (longest period)
  localparam logic [1:0] DB_RESET_CODE = 2'd3;

  // Data line whose buffer may stay on between transactions
  localparam int unsigned INT_LINE = 1;

  // Sideband vector positions
  localparam int unsigned SB_DETECT = 0;
  localparam int unsigned SB_WPROT  = 1;
  localparam int unsigned SB_OOB    = 2;
  localparam int unsigned SB_COUNT  = 3;

endpackage

// File: rtl/card_sideband_dp.sv
module card_sideband_dp
  import card_sideband_pkg::*;
#(
  parameter int unsigned CNT_CODE0 = 33,
  parameter int unsigned CNT_CODE1 = 231,
  parameter int unsigned CNT_CODE2 = 1000,
  parameter int unsigned CNT_CODE3 = 8400
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rawDetect,
  input  logic       rawWrProt,
  input  logic       rawOob,
  input  logic       detectPolarity,
  input  logic       wpPolarity,
  input  logic       oobPolarity,
  input  logic       oobEnable,
  input  logic [1:0] debounceSel,
  input  dbStrobe_t  strobe,
  output logic       normDetect,
  output logic       writeProtected,
  output logic       oobIrq,
  output logic       atLimit,
  output logic       selChanged
);

  localparam int unsigned MAX01  = (CNT_CODE0 > CNT_CODE1) ? CNT_CODE0 : CNT_CODE1;
  localparam int unsigned MAX23  = (CNT_CODE2 > CNT_CODE3) ? CNT_CODE2 : CNT_CODE3;
  localparam int unsigned MAXCNT = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int unsigned CW     = (MAXCNT < 2) ? 1 : $clog2(MAXCNT);

  logic [SB_COUNT-1:0] rawVec, polVec, stage1, stage2, normVec;

  assign rawVec[SB_DETECT] = rawDetect;
  assign rawVec[SB_WPROT]  = rawWrProt;
  assign rawVec[SB_OOB]    = rawOob;
  assign polVec[SB_DETECT] = detectPolarity;
  assign polVec[SB_WPROT]  = wpPolarity;
  assign polVec[SB_OOB]    = oobPolarity;

  // Two-flop synchronizer and polarity normalization per sideband pin
  for (genvar i = 0; i < SB_COUNT; i++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1[i] <= 1'b0;
        stage2[i] <= 1'b0;
      end else begin
        stage1[i] <= rawVec[i];
        stage2[i] <= stage1[i];
      end
    end
    assign normVec[i] = stage2[i] ^ polVec[i];
  end

  assign normDetect     = normVec[SB_DETECT];
  assign writeProtected = normVec[SB_WPROT];
  assign oobIrq         = oobEnable & normVec[SB_OOB];

  // Debounce code register and period counter
  logic [1:0]    selQ;
  logic [CW-1:0] cnt, lastCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selQ <= DB_RESET_CODE;
    else       selQ <= debounceSel;
  end

  assign selChanged = (selQ != debounceSel);

  always_comb begin
    unique case (selQ)
      2'd0:    lastCount = CW'(CNT_CODE0 - 1);
      2'd1:    lastCount = CW'(CNT_CODE1 - 1);
      2'd2:    lastCount = CW'(CNT_CODE2 - 1);
      default: lastCount = CW'(CNT_CODE3 - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (strobe.cntClear) cnt <= '0;
    else if (strobe.cntInc)   cnt <= cnt + 1'b1;
  end

  assign atLimit = (cnt == lastCount);

endmodule

// File: rtl/card_sideband_ctl.sv
module card_sideband_ctl
  import card_sideband_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      normDetect,
  input  logic      atLimit,
  input  logic      selChanged,
  output dbStrobe_t strobe,
  output logic      cardPresent,
  output logic      insertPulse,
  output logic      removePulse
);

  logic presentQ, insQ, remQ;
  logic mismatch, advance, commit;

  assign mismatch = normDetect != presentQ;
  assign advance  = mismatch & ~selChanged & tickEn;
  assign commit   = advance & atLimit;

  always_comb begin
    strobe          = '0;
    strobe.cntClear = ~mismatch | selChanged | commit;
    strobe.cntInc   = advance & ~atLimit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presentQ <= 1'b0;
      insQ     <= 1'b0;
      remQ     <= 1'b0;
    end else begin
      insQ <= commit & normDetect;
      remQ <= commit & ~normDetect;
      if (commit) presentQ <= normDetect;
    end
  end

  assign cardPresent = presentQ;
  assign insertPulse = insQ;
  assign removePulse = remQ;

endmodule

// File: rtl/card_sideband_bufctl.sv
module card_sideband_bufctl
  import card_sideband_pkg::*;
#(
  parameter int unsigned DATA_LINES = 4
) (
  input  logic                  xferActive,
  input  logic                  keepIntLine,
  output logic [DATA_LINES-1:0] datBufEn
);

  for (genvar i = 0; i < DATA_LINES; i++) begin : gBuf
    if (i == INT_LINE) begin : gKeep
      assign datBufEn[i] = xferActive | keepIntLine;
    end else begin : gPlain
      assign datBufEn[i] = xferActive;
    end
  end

endmodule

// File: rtl/card_sideband_cond.sv
module card_sideband_cond
  import card_sideband_pkg::*;
#(
  parameter int unsigned DATA_LINES = 4,
  parameter int unsigned CNT_CODE0  = 33,
  parameter int unsigned CNT_CODE1  = 231,
  parameter int unsigned CNT_CODE2  = 1000,
  parameter int unsigned CNT_CODE3  = 8400
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tickEn,
  input  logic                  rawDetect,
  input  logic                  rawWrProt,
  input  logic                  rawOob,
  input  logic                  detectPolarity,
  input  logic                  wpPolarity,
  input  logic                  oobPolarity,
  input  logic                  oobEnable,
  input  logic                  keepIntLine,
  input  logic [1:0]            debounceSel,
  input  logic                  xferActive,
  output logic                  cardPresent,
  output logic                  insertPulse,
  output logic                  removePulse,
  output logic                  writeProtected,
  output logic                  oobIrq,
  output logic [DATA_LINES-1:0] datBufEn
);

  dbStrobe_t strobe;
  logic      normDetect, atLimit, selChanged;

  card_sideband_dp #(
    .CNT_CODE0(CNT_CODE0),
    .CNT_CODE1(CNT_CODE1),
    .CNT_CODE2(CNT_CODE2),
    .CNT_CODE3(CNT_CODE3)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .rawDetect     (rawDetect),
    .rawWrProt     (rawWrProt),
    .rawOob        (rawOob),
    .detectPolarity(detectPolarity),
    .wpPolarity    (wpPolarity),
    .oobPolarity   (oobPolarity),
    .oobEnable     (oobEnable),
    .debounceSel   (debounceSel),
    .strobe        (strobe),
    .normDetect    (normDetect),
    .writeProtected(writeProtected),
    .oobIrq        (oobIrq),
    .atLimit       (atLimit),
    .selChanged    (selChanged)
  );

  card_sideband_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .normDetect (normDetect),
    .atLimit    (atLimit),
    .selChanged (selChanged),
    .strobe     (strobe),
    .cardPresent(cardPresent),
    .insertPulse(insertPulse),
    .removePulse(removePulse)
  );

  card_sideband_bufctl #(
    .DATA_LINES(DATA_LINES)
  ) u_buf (
    .xferActive (xferActive),
    .keepIntLine(keepIntLine),
    .datBufEn   (datBufEn)
  );

endmodule

// File: rtl/card_sideband_chk.sv
module card_sideband_chk #(
  parameter int unsigned DATA_LINES = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  tickEn,
  input logic                  oobEnable,
  input logic                  keepIntLine,
  input logic                  xferActive,
  input logic                  cardPresent,
  input logic                  insertPulse,
  input logic                  removePulse,
  input logic                  oobIrq,
  input logic [DATA_LINES-1:0] datBufEn
);

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(insertPulse && removePulse)); // R9

  AST_INSERT_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    insertPulse |-> (cardPresent && !$past(cardPresent))); // R9

  AST_REMOVE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    removePulse |-> (!cardPresent && $past(cardPresent))); // R9

  AST_INSERT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    insertPulse |=> !insertPulse); // R9

  AST_PRESENT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !$past(tickEn) |-> $stable(cardPresent)); // R8

  AST_OOB_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !oobEnable |-> !oobIrq); // R4

  AST_BUF_XFER_ON: assert property (@(posedge clk) disable iff (!rstN)
    xferActive |-> (&datBufEn)); // R10

  AST_BUF_IDLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!xferActive && !keepIntLine) |-> (datBufEn == '0)); // R10

endmodule

bind card_sideband_cond card_sideband_chk #(.DATA_LINES(DATA_LINES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .tickEn     (tickEn),
  .oobEnable  (oobEnable),
  .keepIntLine(keepIntLine),
  .xferActive (xferActive),
  .cardPresent(cardPresent),
  .insertPulse(insertPulse),
  .removePulse(removePulse),
  .oobIrq     (oobIrq),
  .datBufEn   (datBufEn)
);

// File: tb/card_sideband_cond_bench.sv
`timescale 1ns/1ps
module card_sideband_cond_bench;

  localparam int L0 = 4, L1 = 6, L2 = 9, L3 = 13;
  localparam int LINES = 4;

  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b1;
  logic rawDetect = 1'b0, rawWrProt = 1'b0, rawOob = 1'b0;
  logic detectPolarity = 1'b0, wpPolarity = 1'b0, oobPolarity = 1'b0;
  logic oobEnable = 1'b0, keepIntLine = 1'b0, xferActive = 1'b0;
  logic [1:0] debounceSel = 2'd0;
  logic cardPresent, insertPulse, removePulse, writeProtected, oobIrq;
  logic [LINES-1:0] datBufEn;

  int cyc = 0, nChecks = 0, nFails = 0;
  int dueQ[$];
  bit kindQ[$];
  string tagQ[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  card_sideband_cond #(
    .DATA_LINES(LINES), .CNT_CODE0(L0), .CNT_CODE1(L1),
    .CNT_CODE2(L2), .CNT_CODE3(L3)
  ) u_card_sideband_cond (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rawDetect(rawDetect),
    .rawWrProt(rawWrProt), .rawOob(rawOob), .detectPolarity(detectPolarity),
    .wpPolarity(wpPolarity), .oobPolarity(oobPolarity), .oobEnable(oobEnable),
    .keepIntLine(keepIntLine), .debounceSel(debounceSel), .xferActive(xferActive),
    .cardPresent(cardPresent), .insertPulse(insertPulse), .removePulse(removePulse),
    .writeProtected(writeProtected), .oobIrq(oobIrq), .datBufEn(datBufEn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Step to just after a falling edge; inputs change here
  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic expectPulse(input int due, input bit isInsert, input string tag);
    dueQ.push_back(due);
    kindQ.push_back(isInsert);
    tagQ.push_back(tag);
  endtask

  task automatic drain();
    for (int g = 0; g < 200 && dueQ.size() != 0; g++) step();
    check(dueQ.size() == 0, "drain", dueQ.size(), 0);
    repeat (3) step();
  endtask

  // Monitor: every pulse must match the oldest expected item
  always @(negedge clk) begin
    if (rstN && (insertPulse || removePulse)) begin
      if (dueQ.size() == 0) begin
        check(1'b0, "R9 unexpected pulse", int'(insertPulse), 0);
      end else begin
        int due;
        bit kind;
        string tag;
        due  = dueQ.pop_front();
        kind = kindQ.pop_front();
        tag  = tagQ.pop_front();
        check(cyc == due, {tag, " pulse cycle"}, cyc, due);
        check(insertPulse == kind && removePulse == !kind, {tag, " R9 pulse kind"},
              int'(insertPulse), int'(kind));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R11 reset state, R10 idle buffers
    check(cardPresent == 1'b0, "R11 present after reset", cardPresent, 0);
    check(insertPulse == 1'b0 && removePulse == 1'b0, "R11 pulses", insertPulse, 0);
    check(datBufEn == 4'b0000, "R10 idle all off", datBufEn, 0);
    repeat (3) step();

    // R5 code 0 insert
    debounceSel = 2'd0; repeat (2) step();
    rawDetect = 1'b1; expectPulse(cyc + 2 + L0, 1'b1, "R5 code0");
    drain();
    check(cardPresent == 1'b1, "R5 present", cardPresent, 1);

    // R5 code 1 remove
    debounceSel = 2'd1; repeat (2) step();
    rawDetect = 1'b0; expectPulse(cyc + 2 + L1, 1'b0, "R5 code1");
    drain();
    // R5 code 2 insert
    debounceSel = 2'd2; repeat (2) step();
    rawDetect = 1'b1; expectPulse(cyc + 2 + L2, 1'b1, "R5 code2");
    drain();
    // R5 code 3 remove
    debounceSel = 2'd3; repeat (2) step();
    rawDetect = 1'b0; expectPulse(cyc + 2 + L3, 1'b0, "R5 code3");
    drain();
    check(cardPresent == 1'b0, "R5 absent", cardPresent, 0);

    // R6 glitch shorter than the period is dropped
    debounceSel = 2'd0; repeat (2) step();
    rawDetect = 1'b1; repeat (3) step();
    rawDetect = 1'b0; repeat (20) step();
    check(cardPresent == 1'b0, "R6 glitch ignored", cardPresent, 0);
    rawDetect = 1'b1; repeat (3) step();
    rawDetect = 1'b0; step();
    rawDetect = 1'b1; expectPulse(cyc + 2 + L0, 1'b1, "R6 restart");
    drain();

    // R7 code change mid-count restarts with the new period
    debounceSel = 2'd3; repeat (2) step();
    rawDetect = 1'b0; repeat (6) step();
    debounceSel = 2'd0; expectPulse(cyc + 1 + L0, 1'b0, "R7 code change");
    drain();

    // R8 no counting without ticks
    tickEn = 1'b0;
    rawDetect = 1'b1; repeat (30) step();
    check(cardPresent == 1'b0, "R8 frozen without tick", cardPresent, 0);
    tickEn = 1'b1; expectPulse(cyc + L0, 1'b1, "R8 tick resume");
    drain();

    // R2 detect polarity
    detectPolarity = 1'b1; expectPulse(cyc + L0, 1'b0, "R2 pol flip low");
    drain();
    rawDetect = 1'b0; expectPulse(cyc + 2 + L0, 1'b1, "R2 active low insert");
    drain();
    check(cardPresent == 1'b1, "R2 active low present", cardPresent, 1);

    // R1 and R3 write-protect path
    rawWrProt = 1'b1; step();
    check(writeProtected == 1'b0, "R1 wp after one edge", writeProtected, 0);
    step();
    check(writeProtected == 1'b1, "R1 wp after two edges", writeProtected, 1);
    wpPolarity = 1'b1; step();
    check(writeProtected == 1'b0, "R3 wp active low high pin", writeProtected, 0);
    rawWrProt = 1'b0; repeat (2) step();
    check(writeProtected == 1'b1, "R3 wp active low low pin", writeProtected, 1);

    // R4 out-of-band gating and polarity
    rawOob = 1'b1; repeat (3) step();
    check(oobIrq == 1'b0, "R4 disabled ignored", oobIrq, 0);
    oobEnable = 1'b1; step();
    check(oobIrq == 1'b1, "R4 enabled high", oobIrq, 1);
    oobPolarity = 1'b1; step();
    check(oobIrq == 1'b0, "R4 active low inactive", oobIrq, 0);
    rawOob = 1'b0; repeat (3) step();
    check(oobIrq == 1'b1, "R4 active low asserted", oobIrq, 1);
    oobEnable = 1'b0; step();
    check(oobIrq == 1'b0, "R4 disabled asserted pin", oobIrq, 0);

    // R10 buffer enables
    xferActive = 1'b1; step();
    check(datBufEn == 4'b1111, "R10 transfer all on", datBufEn, 15);
    xferActive = 1'b0; keepIntLine = 1'b1; step();
    check(datBufEn == 4'b0010, "R10 keep line 1", datBufEn, 2);
    keepIntLine = 1'b0; step();
    check(datBufEn == 4'b0000, "R10 idle off", datBufEn, 0);

    repeat (10) step();
    check(dueQ.size() == 0, "R9 no pending pulses", dueQ.size(), 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule